// File: doc/BRIEF.md
# UART Transmitter with LIN Break Generation

This block is the transmit side of a serial port. Software (or a bus bridge) places a 16-bit word into a single-entry hold buffer. On the next baud tick the transmitter moves that word into its frame shifter and sends a frame on the serial line. A frame is a low start bit, then 6 to 13 data bits in either bit order, then an optional parity bit (even, odd or fixed), then one or two high stop bits. The bit timing comes entirely from an external `baud_tick` strobe: every line change happens on the clock edge where the strobe is high, so one bit lasts from one strobe to the next.

For LIN-style buses, a break field request can be armed. The next frame that loads is then preceded by 13 low bit times and 1 high bit time, and the request disarms itself once that field has gone out. A separate line-forcing input holds the pin low while it is asserted. It leaves the frame sequencing untouched, so the frame keeps its timing underneath. The serial output and a request-to-send style output can each be inverted. The block issues one-cycle start and end event pulses for each frame and reports whether the hold buffer is empty or full.

Top module: `uart_lin_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, the internal line level is 1, so `txd` equals `line_inv` (while `break_force` is 0). After reset `buf_empty`=1, `buf_full`=0, `lin_brk_pending`=0 and `rts_o`=`rts_inv`.
- R2: The data-bit count is `wlen_cfg` when it is in 6..13. Values below 6 are sent as 6 bits, and values above 13 are sent as 13 bits. The word's low-order bits are the data.
- R3: A frame starts with one 0 bit. With `lsb_first`=1 data bit 0 goes out first. With `lsb_first`=0 the data goes out from bit (count-1) down to bit 0.
- R4: With `par_en`=1 a parity bit follows the data. `par_even`=1 makes the count of ones in data plus parity even, and `par_even`=0 makes it odd. With `par_stick`=1 the parity bit is the constant 1 when `par_even`=0 and 0 when `par_even`=1. With `par_en`=0 no parity bit is sent.
- R5: The frame ends with one stop bit of value 1 when `two_stop`=0, and with two such bits when `two_stop`=1.
- R6: A `lin_brk_set` pulse sets `lin_brk_pending`. The next frame to load is preceded by 13 bits of 0 and then 1 bit of 1. `lin_brk_pending` returns to 0 on the tick that completes that high bit, and frames loaded after that carry no break field.
- R7: While `break_force`=1, `txd` is 0 regardless of `line_inv`. Bit timing, `tx_start`, `tx_end` and the buffer flags proceed exactly as if it were 0.
- R8: `txd` is the internal line level XOR `line_inv`. `rts_o` is (frame in progress OR hold buffer full) XOR `rts_inv`.
- R9: A one-cycle `tx_rst` empties the hold buffer, aborts any frame, returns the line to idle level 1 and drops pending events, all by the next cycle. Writes in that cycle are discarded, and `lin_brk_pending` is kept.
- R10: `tx_start` is high for exactly the one cycle after the tick that loads a word, which is the first cycle of its break field or start bit. `tx_end` is high for the one cycle after the tick that completes the last stop bit.
- R11: `wr_en` stores `wr_data` only when the buffer is empty. A write while the buffer is full is discarded and leaves the stored word unchanged. `buf_empty` is the inverse of `buf_full`.
- R12: The line changes only on clock edges where `baud_tick`=1 (or on `tx_rst`). A word waiting in the buffer at the tick that completes a frame loads on that same tick, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-time strobe |
| wr_en | input | 1 | Write strobe for the hold buffer |
| wr_data | input | 16 | Word to send, right-aligned |
| tx_rst | input | 1 | One-cycle transmit-path clear |
| lin_brk_set | input | 1 | Arm a LIN break field before the next frame |
| wlen_cfg | input | 4 | Data-bit count (6..13, clamped) |
| lsb_first | input | 1 | 1: bit 0 first; 0: top bit first |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1: even parity; 0: odd parity |
| par_stick | input | 1 | Parity bit fixed at the inverse of par_even |
| two_stop | input | 1 | 1: two stop bits; 0: one |
| line_inv | input | 1 | Invert the serial output |
| rts_inv | input | 1 | Invert the request-to-send output |
| break_force | input | 1 | Hold txd low, sequencing unaffected |
| txd | output | 1 | Serial data output |
| rts_o | output | 1 | Request-to-send style control output |
| tx_start | output | 1 | Frame-start event pulse |
| tx_end | output | 1 | Frame-end event pulse |
| buf_empty | output | 1 | Hold buffer empty |
| buf_full | output | 1 | Hold buffer full |
| lin_brk_pending | output | 1 | Break field armed and not yet completed |

## Verification
The assertions take for granted that `rst_n` and `tx_rst` are sampled synchronously. Their pulse checks also rely on every frame spanning at least eight baud ticks, which the shortest legal frame guarantees whatever the tick spacing. The framing inputs are sampled only on the loading tick. The stimulus therefore changes word length, order, parity and stop settings only while the line is idle, and toggles `break_force`, `line_inv` and `rts_inv` at any time. Ticks are generated every four cycles, every three cycles, and on every cycle. The every-cycle case exercises back-to-back loading and single-cycle bit times.

// File: rtl/uart_lin_tx_pkg.sv
// Shared sizing for the UART transmit path with LIN break generation.
// Assumes: data bus is 16 bits wide; frame lengths derive from the limits below.
package uart_lin_tx_pkg;
    parameter int DATA_W   = 16;
    parameter int WLEN_W   = 4;
    parameter int MIN_WLEN = 6;
    parameter int MAX_WLEN = 13;
    parameter int BRK_LOW  = 13;
    parameter int BRK_HIGH = 1;
    parameter int MAX_STOP = 2;

    localparam int BRK_LEN = BRK_LOW + BRK_HIGH;
    localparam int FRAME_W = BRK_LEN + 1 + MAX_WLEN + 1 + MAX_STOP;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int IDX_W   = $clog2(DATA_W);
endpackage

// File: rtl/uart_lin_tx_hold.sv
// One-entry transmit hold buffer.
// Accepts a word only while empty; the serializer pops it on a loading tick.
// Assumes: pop is only raised while full.
module uart_lin_tx_hold
    import uart_lin_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Purpose: hold one word; reset or clear empties it, writes when full are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !tx_rst) |=> (full && $stable(data))); // R11
endmodule

// File: rtl/uart_lin_tx_frame.sv
// Combinational frame assembler.
// Lays out break field, start bit, data, parity and stop bits into one vector,
// bit 0 sent first, and reports the total and break-free lengths.
// Assumes: the caller samples the result only on a loading tick.
module uart_lin_tx_frame
    import uart_lin_tx_pkg::*;
(
    input  logic [DATA_W-1:0]  word,
    input  logic [WLEN_W-1:0]  wlen_cfg,
    input  logic               lsb_first,
    input  logic               par_en,
    input  logic               par_even,
    input  logic               par_stick,
    input  logic               two_stop,
    input  logic               with_brk,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   frame_len,
    output logic [CNT_W-1:0]   data_len
);
    logic [WLEN_W-1:0] nbits;
    logic [DATA_W-1:0] masked;
    logic              parity_bit;

    // Purpose: clamp the configured word length into the legal range.
    always_comb begin
        if (wlen_cfg < WLEN_W'(MIN_WLEN))      nbits = WLEN_W'(MIN_WLEN);
        else if (wlen_cfg > WLEN_W'(MAX_WLEN)) nbits = WLEN_W'(MAX_WLEN);
        else                                   nbits = wlen_cfg;
    end

    // Purpose: keep only the active data bits for the parity reduction.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = word[i] && (i < int'(nbits));
        end
    end

    // Purpose: choose computed or stick parity.
    always_comb begin
        if (par_stick)     parity_bit = ~par_even;
        else if (par_even) parity_bit = ^masked;
        else               parity_bit = ~(^masked);
    end

    // Purpose: place every field of the frame in send order.
    always_comb begin
        logic [CNT_W-1:0] pos;
        frame = '1;
        pos   = '0;
        if (with_brk) begin
            for (int i = 0; i < BRK_LOW; i++) begin
                frame[i] = 1'b0;
            end
            pos = CNT_W'(BRK_LEN);
        end
        frame[pos] = 1'b0;
        pos = pos + 1'b1;
        for (int i = 0; i < MAX_WLEN; i++) begin
            if (i < int'(nbits)) begin
                frame[pos + CNT_W'(i)] = lsb_first ? word[IDX_W'(i)]
                                       : word[IDX_W'(nbits) - 1'b1 - IDX_W'(i)];
            end
        end
        pos = pos + CNT_W'(nbits);
        if (par_en) begin
            frame[pos] = parity_bit;
            pos = pos + 1'b1;
        end
        pos = pos + (two_stop ? CNT_W'(2) : CNT_W'(1));
        frame_len = pos;
    end

    // Purpose: length of the frame without any break field.
    always_comb begin
        data_len = CNT_W'(1) + CNT_W'(nbits) + CNT_W'(par_en) + (two_stop ? CNT_W'(2) : CNT_W'(1));
    end
endmodule

// File: rtl/uart_lin_tx_shift.sv
// Frame shifter and bit sequencer.
// Loads an assembled frame on a baud tick, shifts one bit per tick, raises
// start/end events, and owns the self-clearing LIN break request.
// Assumes: every frame is at least eight bits long.
module uart_lin_tx_shift
    import uart_lin_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_rst,
    input  logic               baud_tick,
    input  logic               buf_full,
    input  logic               lin_brk_set,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   frame_len,
    input  logic [CNT_W-1:0]   data_len,
    output logic               load,
    output logic               brk_flag,
    output logic               line,
    output logic               busy,
    output logic               tx_start,
    output logic               tx_end
);
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   dlen_q;
    logic               brk_on_q;
    logic               last_bit;
    logic               brk_clear;

    assign last_bit  = busy && (cnt_q == CNT_W'(1));
    assign load      = baud_tick && buf_full && !tx_rst && (!busy || last_bit);
    assign brk_clear = baud_tick && busy && brk_on_q && !tx_rst && (cnt_q == dlen_q + 1'b1);
    assign line      = frame_q[0];

    // Purpose: advance the frame one bit per tick and chain the next word.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_rst) begin
            frame_q  <= '1;
            cnt_q    <= '0;
            dlen_q   <= '0;
            brk_on_q <= 1'b0;
            busy     <= 1'b0;
            tx_start <= 1'b0;
            tx_end   <= 1'b0;
        end else begin
            tx_start <= load;
            tx_end   <= baud_tick && last_bit;
            if (baud_tick) begin
                if (busy && !last_bit) begin
                    frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                    cnt_q   <= cnt_q - 1'b1;
                    if (brk_clear) brk_on_q <= 1'b0;
                end else if (load) begin
                    frame_q  <= frame_in;
                    cnt_q    <= frame_len;
                    dlen_q   <= data_len;
                    brk_on_q <= brk_flag;
                    busy     <= 1'b1;
                end else begin
                    frame_q  <= '1;
                    cnt_q    <= '0;
                    brk_on_q <= 1'b0;
                    busy     <= 1'b0;
                end
            end
        end
    end

    // Purpose: arm the break request; it disarms when its field completes.
    always_ff @(posedge clk) begin
        if (!rst_n)           brk_flag <= 1'b0;
        else if (lin_brk_set) brk_flag <= 1'b1;
        else if (brk_clear)   brk_flag <= 1'b0;
    end

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line); // R1
    AST_BRK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clear && !lin_brk_set) |=> !brk_flag); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R10
    AST_END_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> $past(busy)); // R10
    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !tx_rst) |=> $stable(line)); // R12
endmodule

// File: rtl/uart_lin_tx.sv
// UART transmit path with LIN break field and line-forcing break.
// Wires hold buffer, frame assembler and shifter; applies output polarity.
// Assumes: baud_tick is a one-cycle strobe per bit time; framing inputs are
// stable across a loading tick.
module uart_lin_tx
    import uart_lin_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_rst,
    input  logic              lin_brk_set,
    input  logic [WLEN_W-1:0] wlen_cfg,
    input  logic              lsb_first,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              two_stop,
    input  logic              line_inv,
    input  logic              rts_inv,
    input  logic              break_force,
    output logic              txd,
    output logic              rts_o,
    output logic              tx_start,
    output logic              tx_end,
    output logic              buf_empty,
    output logic              buf_full,
    output logic              lin_brk_pending
);
    logic [DATA_W-1:0]  held_word;
    logic [FRAME_W-1:0] frame_vec;
    logic [CNT_W-1:0]   frame_len;
    logic [CNT_W-1:0]   data_len;
    logic               load;
    logic               brk_flag;
    logic               line;
    logic               busy;

    uart_lin_tx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_rst  (tx_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (load),
        .full    (buf_full),
        .data    (held_word)
    );

    uart_lin_tx_frame u_frame (
        .word      (held_word),
        .wlen_cfg  (wlen_cfg),
        .lsb_first (lsb_first),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .two_stop  (two_stop),
        .with_brk  (brk_flag),
        .frame     (frame_vec),
        .frame_len (frame_len),
        .data_len  (data_len)
    );

    uart_lin_tx_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_rst      (tx_rst),
        .baud_tick   (baud_tick),
        .buf_full    (buf_full),
        .lin_brk_set (lin_brk_set),
        .frame_in    (frame_vec),
        .frame_len   (frame_len),
        .data_len    (data_len),
        .load        (load),
        .brk_flag    (brk_flag),
        .line        (line),
        .busy        (busy),
        .tx_start    (tx_start),
        .tx_end      (tx_end)
    );

    // Purpose: pin polarity, line forcing and status outputs.
    always_comb begin
        txd             = break_force ? 1'b0 : (line ^ line_inv);
        rts_o           = (busy | buf_full) ^ rts_inv;
        buf_empty       = ~buf_full;
        lin_brk_pending = brk_flag;
    end

    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (!buf_full && !busy && line && !tx_start && !tx_end)); // R9
endmodule

// File: tb/sim_uart_lin_tx.sv
// Bench: behavioural queue model of the line, compared every clock.
module sim_uart_lin_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tx_rst = 1'b0;
    logic        lin_brk_set = 1'b0;
    logic [3:0]  wlen_cfg = 4'd8;
    logic        lsb_first = 1'b1;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        par_stick = 1'b0;
    logic        two_stop = 1'b0;
    logic        line_inv = 1'b0;
    logic        rts_inv = 1'b0;
    logic        break_force = 1'b0;
    logic        txd, rts_o, tx_start, tx_end, buf_empty, buf_full, lin_brk_pending;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    tick_div = 4;
    int    tcnt = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R1";

    // Reference model state
    bit        m_q[$];
    bit        m_full = 1'b0;
    bit [15:0] m_data = '0;
    bit        m_start = 1'b0;
    bit        m_end = 1'b0;
    bit        m_flag = 1'b0;
    int        m_brk_rem = 0;

    uart_lin_tx u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .tx_rst(tx_rst), .lin_brk_set(lin_brk_set), .wlen_cfg(wlen_cfg), .lsb_first(lsb_first),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .two_stop(two_stop),
        .line_inv(line_inv), .rts_inv(rts_inv), .break_force(break_force), .txd(txd),
        .rts_o(rts_o), .tx_start(tx_start), .tx_end(tx_end), .buf_empty(buf_empty),
        .buf_full(buf_full), .lin_brk_pending(lin_brk_pending)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R12 watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
            $finish;
        end
    end

    // Tick generator: a strobe every tick_div cycles.
    always @(posedge clk) begin
        #1;
        tcnt = tcnt + 1;
        if (tcnt >= tick_div) begin
            tcnt = 0;
            baud_tick = 1'b1;
        end else begin
            baud_tick = 1'b0;
        end
    end

    // Push the bits of one frame in send order, built from the requirements.
    task automatic push_frame(input bit [15:0] w, input bit brk);
        int n;
        int ones;
        bit pb;
        n = int'(wlen_cfg);
        if (n < 6) n = 6;
        if (n > 13) n = 13;
        if (brk) begin
            repeat (13) m_q.push_back(1'b0);
            m_q.push_back(1'b1);
        end
        m_q.push_back(1'b0);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            m_q.push_back(lsb_first ? w[i] : w[n - 1 - i]);
            if (w[i]) ones++;
        end
        if (par_en) begin
            if (par_stick)     pb = !par_even;
            else if (par_even) pb = (ones % 2) == 1;
            else               pb = (ones % 2) == 0;
            m_q.push_back(pb);
        end
        m_q.push_back(1'b1);
        if (two_stop) m_q.push_back(1'b1);
    endtask

    // Reference model: advance on every clock edge.
    always @(posedge clk) begin
        bit full_pre;
        bit clr;
        full_pre = m_full;
        clr = 1'b0;
        m_start = 1'b0;
        m_end = 1'b0;
        if (!rst_n) begin
            m_q.delete();
            m_full = 1'b0;
            m_data = '0;
            m_flag = 1'b0;
            m_brk_rem = 0;
        end else if (tx_rst) begin
            m_q.delete();
            m_full = 1'b0;
            m_data = '0;
            m_brk_rem = 0;
            if (lin_brk_set) m_flag = 1'b1;
        end else begin
            if (baud_tick) begin
                if (m_q.size() > 1) begin
                    void'(m_q.pop_front());
                    if (m_brk_rem > 0) begin
                        m_brk_rem--;
                        if (m_brk_rem == 0) clr = 1'b1;
                    end
                end else begin
                    if (m_q.size() == 1) begin
                        m_end = 1'b1;
                        void'(m_q.pop_front());
                    end
                    if (m_full) begin
                        push_frame(m_data, m_flag);
                        m_brk_rem = m_flag ? 14 : 0;
                        m_full = 1'b0;
                        m_start = 1'b1;
                    end
                end
            end
            if (lin_brk_set)  m_flag = 1'b1;
            else if (clr)     m_flag = 1'b0;
            if (wr_en && !full_pre) begin
                m_full = 1'b1;
                m_data = wr_data;
            end
        end
    end

    task automatic check1(input string nm, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from the clock edge.
    always @(negedge clk) begin
        logic lvl;
        if (chk_en) begin
            lvl = (m_q.size() > 0) ? m_q[0] : 1'b1;
            check1("txd", txd, break_force ? 1'b0 : (lvl ^ line_inv));
            check1("rts_o", rts_o, ((m_q.size() > 0) || m_full) ^ rts_inv);
            check1("tx_start", tx_start, m_start);
            check1("tx_end", tx_end, m_end);
            check1("buf_full", buf_full, m_full);
            check1("buf_empty", buf_empty, !m_full);
            check1("lin_brk_pending", lin_brk_pending, m_flag);
        end
    end

    task automatic write_word(input logic [15:0] w);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_data = w;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_full || m_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        chk_en = 1'b1;

        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        check1("reset txd", txd, 1'b1);
        check1("reset buf_empty", buf_empty, 1'b1);
        check1("reset buf_full", buf_full, 1'b0);
        check1("reset rts_o", rts_o, 1'b0);
        check1("reset lin_brk_pending", lin_brk_pending, 1'b0);
        cycles(2);

        // R3: both bit orders
        cur_req = "R3";
        wlen_cfg = 4'd8; lsb_first = 1'b1;
        write_word(16'h00A5); wait_idle();
        lsb_first = 1'b0;
        write_word(16'h0035); wait_idle();
        lsb_first = 1'b1;

        // R2: length limits and clamping
        cur_req = "R2";
        wlen_cfg = 4'd6;  write_word(16'h003F); wait_idle();
        wlen_cfg = 4'd13; write_word(16'h1ABC); wait_idle();
        wlen_cfg = 4'd3;  write_word(16'h002D); wait_idle();
        wlen_cfg = 4'd15; lsb_first = 1'b0; write_word(16'hFFF0); wait_idle();
        lsb_first = 1'b1; wlen_cfg = 4'd8;

        // R4: parity kinds
        cur_req = "R4";
        par_en = 1'b1;
        par_even = 1'b1; write_word(16'h0007); wait_idle();
        par_even = 1'b0; write_word(16'h0007); wait_idle();
        par_even = 1'b1; write_word(16'h0003); wait_idle();
        par_stick = 1'b1;
        par_even = 1'b1; write_word(16'h000F); wait_idle();
        par_even = 1'b0; write_word(16'h000F); wait_idle();
        par_stick = 1'b0; par_en = 1'b0;

        // R5: two stop bits
        cur_req = "R5";
        two_stop = 1'b1; write_word(16'h0081); wait_idle();
        two_stop = 1'b0;

        // R11: buffer fills while busy; third write discarded
        cur_req = "R11";
        write_word(16'h0011);
        cycles(12);
        write_word(16'h0022);
        write_word(16'h0033);
        @(negedge clk);
        check1("full after second write", buf_full, 1'b1);
        wait_idle();

        // R12: tick every cycle, back-to-back frames
        cur_req = "R12";
        tick_div = 1;
        write_word(16'h00C3);
        write_word(16'h003C);
        wait_idle();
        tick_div = 3;

        // R10: start and end events
        cur_req = "R10";
        write_word(16'h0055); wait_idle();
        tick_div = 4;

        // R6: LIN break field, self-clearing
        cur_req = "R6";
        @(posedge clk); #1; lin_brk_set = 1'b1;
        @(posedge clk); #1; lin_brk_set = 1'b0;
        @(negedge clk);
        check1("break armed", lin_brk_pending, 1'b1);
        write_word(16'h00E1);
        cycles(20);
        write_word(16'h001E);
        wait_idle();
        @(negedge clk);
        check1("break disarmed", lin_brk_pending, 1'b0);

        // R7: forced low without disturbing sequencing
        cur_req = "R7";
        write_word(16'h00FF);
        cycles(14);
        break_force = 1'b1;
        cycles(10);
        break_force = 1'b0;
        wait_idle();
        break_force = 1'b1; cycles(5); break_force = 1'b0;

        // R8: inversion of both outputs
        cur_req = "R8";
        line_inv = 1'b1; rts_inv = 1'b1;
        write_word(16'h0096); wait_idle();
        line_inv = 1'b0; rts_inv = 1'b0;

        // R9: transmit reset mid-frame with buffer full
        cur_req = "R9";
        write_word(16'h0077);
        cycles(20);
        write_word(16'h0088);
        @(posedge clk); #1; tx_rst = 1'b1;
        @(posedge clk); #1; tx_rst = 1'b0;
        @(negedge clk);
        check1("empty after clear", buf_empty, 1'b1);
        check1("idle line after clear", txd, 1'b1);
        cycles(10);
        write_word(16'h0044); wait_idle();

        chk_en = 1'b0;
        summary();
        $finish;
    end
endmodule